// File: doc/BRIEF.md
# Debug access command sequencer

This block sits between a debug host and a scan engine. It accepts one high-level request at a time: enter debug mode, halt with forced access, read a location, write a location, or reset the CPU. It expands each request into an ordered series of scans, and each scan carries a 32-bit payload word to a selected target register. The sequencer builds every payload itself, including the transfer descriptor, the mode-flag words and the strobe word.

For a CPU reset, the block polls the target's status word until the reset acknowledge bit appears. Polling stops after a programmable number of attempts, and the request then ends with an error. Every request ends with a single-cycle completion pulse that carries the read data and an error flag.

Top module: `dbg_cmd_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle, and a request is taken only on `req_valid && req_ready`. After reset the block is idle, with `scan_valid` and `resp_done` low. Opcodes are 0 enter debug, 1 forced halt, 2 read, 3 write and 4 CPU reset. Opcodes 5 to 7 issue no scan and complete with `resp_err` set.
- R2: The descriptor scan (`scan_sel` 4) carries zero in bits 31:27, the cycle type in bits 26:24 and the address in bits 23:0. The cycle type is 0 for program memory, 1 for data memory and 2 for a CPU register, whose index goes in the address field.
- R3: A read issues the descriptor scan and then one data scan (`scan_sel` 5, word 0). `resp_data` is the `scan_rdata` returned on that data scan. While `scan_valid` is high and `scan_done` is low, `scan_sel` and `scan_word` hold steady.
- R4: A register read (cycle type 2) is zero-extended to the register's width. Index 14 keeps 22 bits. Indexes 11, 12, 13 and 192 keep 16 bits. All other indexes, such as 0 to 7, 224 and 256, keep 32 bits.
- R5: A write issues the descriptor scan and then a data scan carrying `req_wdata`. Its `resp_data` is 0.
- R6: Enter debug issues a Test-Logic-Reset scan (`scan_sel` 0) and then a strobe scan (`scan_sel` 1) with word 0x000000AA. The remaining select codes are 2 for mode-flag word 0, 3 for mode-flag word 1, 6 for a status poll and 7 for a single step.
- R7: A forced halt issues one mode-flag-0 scan with word 0x000000FF. Bit 7 loads the qualifiers, bit 6 ignores high-priority-interrupt protection, bit 5 ignores the debug mask, and bits 4:0 set the debug frame to all ones.
- R8: A CPU reset issues four steps in order: mode-flag 1 with bit 0 set (word 1), one single step, status polls until the returned bit 0 is 1, then mode-flag 1 with word 0. It ends without error.
- R9: If `cfg_poll_max` (at least 1) polls return bit 0 clear, the reset ends with `resp_err` set, skips the clearing scan, and returns to idle.
- R10: `resp_done` is a one-cycle pulse, given exactly once for each accepted request. A request offered while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_poll_max | input | POLL_W | Maximum status polls during CPU reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_op | input | 3 | Request opcode |
| req_cycle | input | 3 | Transfer cycle type |
| req_addr | input | 24 | Address or register index |
| req_wdata | input | 32 | Write data |
| scan_valid | output | 1 | Scan requested, held until done |
| scan_sel | output | 3 | Target register of the scan |
| scan_word | output | 32 | Payload shifted in |
| scan_done | input | 1 | Scan finished, one-cycle pulse |
| scan_rdata | input | 32 | Payload captured on the finished scan |
| resp_done | output | 1 | Request complete pulse |
| resp_data | output | 32 | Read result |
| resp_err | output | 1 | Request failed (timeout or bad opcode) |

## Verification
A wrong state shows at the ports at the next scan. Either `scan_sel` names the wrong target or the payload word is wrong, and the bench logs every completed scan to compare the whole order. A stuck or misrouted poll counter changes the number of status scans and the `resp_err` value in the cycle after the last poll. A bad width selection shows in `resp_data` on the same completion pulse.

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq #(
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POLL_W-1:0] cfg_poll_max,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [2:0]        req_cycle,
  input  logic [23:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              scan_valid,
  output logic [2:0]        scan_sel,
  output logic [31:0]       scan_word,
  input  logic              scan_done,
  input  logic [31:0]       scan_rdata,
  output logic              resp_done,
  output logic [31:0]       resp_data,
  output logic              resp_err
);

  typedef enum logic [3:0] {
    IDLE, S_TLR, S_STRB, S_MF0, S_DESC, S_DATA, S_MF1SET, S_STEP, S_POLL, S_MF1CLR
  } st_t;

  st_t              st;
  logic [2:0]       op_q, cyc_q;
  logic [23:0]      addr_q;
  logic [31:0]      wdata_q;
  logic [POLL_W-1:0] poll_cnt;
  logic [31:0]      rd_masked;

  assign req_ready  = (st == IDLE);
  assign scan_valid = (st != IDLE);

  always_comb begin
    scan_sel  = 3'd0;
    scan_word = 32'd0;
    case (st)
      S_STRB:   begin scan_sel = 3'd1; scan_word = 32'h0000_00AA; end
      S_MF0:    begin scan_sel = 3'd2; scan_word = 32'h0000_00FF; end
      S_DESC:   begin scan_sel = 3'd4; scan_word = {5'd0, cyc_q, addr_q}; end
      S_DATA:   begin scan_sel = 3'd5; scan_word = (op_q == 3'd3) ? wdata_q : 32'd0; end
      S_MF1SET: begin scan_sel = 3'd3; scan_word = 32'd1; end
      S_STEP:   scan_sel = 3'd7;
      S_POLL:   scan_sel = 3'd6;
      S_MF1CLR: scan_sel = 3'd3;
      default:  ;
    endcase
  end

  always_comb begin
    rd_masked = scan_rdata;
    if (cyc_q == 3'd2) begin
      if (addr_q == 24'd14)
        rd_masked = {10'd0, scan_rdata[21:0]};
      else if (addr_q == 24'd11 || addr_q == 24'd12 || addr_q == 24'd13 || addr_q == 24'd192)
        rd_masked = {16'd0, scan_rdata[15:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      op_q      <= '0;
      cyc_q     <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      poll_cnt  <= '0;
      resp_done <= 1'b0;
      resp_data <= '0;
      resp_err  <= 1'b0;
    end else begin
      resp_done <= 1'b0;
      if (st == IDLE) begin
        if (req_valid) begin
          op_q    <= req_op;
          cyc_q   <= req_cycle;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          case (req_op)
            3'd0:      st <= S_TLR;
            3'd1:      st <= S_MF0;
            3'd2, 3'd3: st <= S_DESC;
            3'd4:      st <= S_MF1SET;
            default: begin
              resp_done <= 1'b1;
              resp_err  <= 1'b1;
              resp_data <= '0;
            end
          endcase
        end
      end else if (scan_done) begin
        case (st)
          S_TLR:    st <= S_STRB;
          S_DESC:   st <= S_DATA;
          S_MF1SET: st <= S_STEP;
          S_STEP: begin
            st       <= S_POLL;
            poll_cnt <= '0;
          end
          S_POLL: begin
            if (scan_rdata[0])
              st <= S_MF1CLR;
            else if (poll_cnt + 1'b1 >= cfg_poll_max) begin
              st        <= IDLE;
              resp_done <= 1'b1;
              resp_err  <= 1'b1;
              resp_data <= '0;
            end else
              poll_cnt <= poll_cnt + 1'b1;
          end
          default: begin
            st        <= IDLE;
            resp_done <= 1'b1;
            resp_err  <= 1'b0;
            resp_data <= (st == S_DATA && op_q == 3'd2) ? rd_masked : 32'd0;
          end
        endcase
      end
    end
  end

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !scan_valid);
  assert_scan_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && !scan_done) |=> (scan_valid && $stable(scan_sel) && $stable(scan_word)));
  assert_strobe_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && scan_sel == 3'd1) |-> scan_word == 32'h0000_00AA);
  assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL && cfg_poll_max != '0) |-> poll_cnt < cfg_poll_max);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_op <= 3'd4) |=> !req_ready);

endmodule

// File: tb/dbg_cmd_seq_test.sv
module dbg_cmd_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [7:0]  cfg_poll_max;
  logic        req_valid, req_ready;
  logic [2:0]  req_op, req_cycle;
  logic [23:0] req_addr;
  logic [31:0] req_wdata;
  logic        scan_valid;
  logic [2:0]  scan_sel;
  logic [31:0] scan_word;
  logic        scan_done;
  logic [31:0] scan_rdata;
  logic        resp_done;
  logic [31:0] resp_data;
  logic        resp_err;

  dbg_cmd_seq #(.POLL_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_poll_max(cfg_poll_max),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_cycle(req_cycle), .req_addr(req_addr), .req_wdata(req_wdata),
    .scan_valid(scan_valid), .scan_sel(scan_sel), .scan_word(scan_word),
    .scan_done(scan_done), .scan_rdata(scan_rdata),
    .resp_done(resp_done), .resp_data(resp_data), .resp_err(resp_err)
  );

  int checks = 0, fails = 0;
  int nlog = 0, npoll = 0, ack_at = 0, ndone = 0;
  logic [31:0] mem_val = '0;
  logic [2:0]  log_sel [32];
  logic [31:0] log_word [32];
  logic [31:0] got_data;
  logic        got_err;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  cyc;
    logic [23:0] addr;
    logic [31:0] wdata;
    logic [31:0] mem;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd2, 3'd0, 24'h123456, 32'h0,         32'hDEADBEEF, 32'hDEADBEEF},
    '{3'd2, 3'd1, 24'hFFFFFF, 32'h0,         32'h01234567, 32'h01234567},
    '{3'd2, 3'd2, 24'd224,    32'h0,         32'hCAFEF00D, 32'hCAFEF00D},
    '{3'd2, 3'd2, 24'd14,     32'h0,         32'hFFFFFFFF, 32'h003FFFFF},
    '{3'd2, 3'd2, 24'd192,    32'h0,         32'hFFFFFFFF, 32'h0000FFFF},
    '{3'd2, 3'd2, 24'd13,     32'h0,         32'h12345678, 32'h00005678},
    '{3'd3, 3'd1, 24'h000400, 32'hA5A55A5A,  32'h0,        32'h0},
    '{3'd2, 3'd2, 24'd256,    32'h0,         32'h80000001, 32'h80000001}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    int cnt = 0;
    scan_done = 1'b0;
    scan_rdata = '0;
    forever begin
      @(negedge clk);
      if (scan_done) begin
        scan_done = 1'b0;
        cnt = 0;
      end else if (scan_valid) begin
        if (cnt == 2) begin
          if (nlog < 32) begin
            log_sel[nlog] = scan_sel;
            log_word[nlog] = scan_word;
          end
          nlog++;
          if (scan_sel == 3'd5) scan_rdata = mem_val;
          else if (scan_sel == 3'd6) begin
            npoll++;
            scan_rdata = (ack_at != 0 && npoll >= ack_at) ? 32'h1 : 32'hFFFF_FFFE;
          end else scan_rdata = 32'h5555_5555;
          scan_done = 1'b1;
        end else cnt++;
      end
    end
  end

  always @(posedge clk) if (resp_done) ndone++;

  task automatic issue(input logic [2:0] op, input logic [2:0] cyc, input logic [23:0] addr, input logic [31:0] wd);
    int guard;
    nlog = 0;
    npoll = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_cycle = cyc; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!resp_done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    got_data = resp_data;
    got_err = resp_err;
    check(resp_done == 1'b1, "R10 completion seen", {31'd0, resp_done}, 32'd1);
    @(negedge clk);
    check(resp_done == 1'b0, "R10 pulse one cycle", {31'd0, resp_done}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_cycle = '0;
    req_addr = '0; req_wdata = '0; cfg_poll_max = 8'd8;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", {31'd0, req_ready}, 32'd1);
    check(scan_valid == 1'b0, "R1 reset no scan", {31'd0, scan_valid}, 32'd0);
    check(resp_done == 1'b0, "R1 reset no done", {31'd0, resp_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      mem_val = VEC[i].mem;
      issue(VEC[i].op, VEC[i].cyc, VEC[i].addr, VEC[i].wdata);
      check(got_data == VEC[i].exp, (VEC[i].op == 3'd3) ? "R5 write data" : "R3 R4 read data", got_data, VEC[i].exp);
      check(got_err == 1'b0, "R3 no error", {31'd0, got_err}, 32'd0);
      check(nlog == 2, "R3 R5 scan count", nlog, 2);
      check(log_sel[0] == 3'd4 && log_word[0] == {5'd0, VEC[i].cyc, VEC[i].addr},
            "R2 descriptor word", log_word[0], {5'd0, VEC[i].cyc, VEC[i].addr});
      check(log_sel[1] == 3'd5 && log_word[1] == ((VEC[i].op == 3'd3) ? VEC[i].wdata : 32'd0),
            "R5 data scan word", log_word[1], (VEC[i].op == 3'd3) ? VEC[i].wdata : 32'd0);
    end

    issue(3'd0, 3'd0, 24'd0, 32'd0);
    check(nlog == 2 && log_sel[0] == 3'd0, "R6 TLR first", {29'd0, log_sel[0]}, 32'd0);
    check(log_sel[1] == 3'd1 && log_word[1] == 32'hAA, "R6 strobe word", log_word[1], 32'hAA);

    issue(3'd1, 3'd0, 24'd0, 32'd0);
    check(nlog == 1 && log_sel[0] == 3'd2 && log_word[0] == 32'hFF, "R7 halt word", log_word[0], 32'hFF);

    ack_at = 3; cfg_poll_max = 8'd8;
    issue(3'd4, 3'd0, 24'd0, 32'd0);
    check(nlog == 6, "R8 reset scan count", nlog, 6);
    check(log_sel[0] == 3'd3 && log_word[0] == 32'd1, "R8 set reset bit", log_word[0], 32'd1);
    check(log_sel[1] == 3'd7, "R8 single step", {29'd0, log_sel[1]}, 32'd7);
    check(log_sel[2] == 3'd6 && log_sel[4] == 3'd6, "R8 polls", {29'd0, log_sel[4]}, 32'd6);
    check(log_sel[5] == 3'd3 && log_word[5] == 32'd0, "R8 clear reset bit", log_word[5], 32'd0);
    check(got_err == 1'b0, "R8 no error", {31'd0, got_err}, 32'd0);

    ack_at = 0; cfg_poll_max = 8'd4;
    issue(3'd4, 3'd0, 24'd0, 32'd0);
    check(got_err == 1'b1, "R9 timeout error", {31'd0, got_err}, 32'd1);
    check(npoll == 4, "R9 poll count", npoll, 4);
    check(nlog == 6 && log_sel[5] == 3'd6, "R9 no clear scan", nlog, 6);
    check(req_ready == 1'b1, "R9 back to idle", {31'd0, req_ready}, 32'd1);

    issue(3'd6, 3'd0, 24'd0, 32'd0);
    check(got_err == 1'b1 && nlog == 0, "R1 bad opcode", {31'd0, got_err}, 32'd1);

    ack_at = 2; cfg_poll_max = 8'd8; nlog = 0; npoll = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd4;
    @(negedge clk);
    req_op = 3'd1;
    for (int k = 0; k < 5; k++) begin
      check(req_ready == 1'b0, "R10 busy not ready", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    ndone = 0;
    while (!resp_done) @(negedge clk);
    repeat (10) @(negedge clk);
    check(ndone == 1, "R10 one done per request", ndone, 1);
    check(nlog == 5 && log_sel[0] == 3'd3, "R10 busy request ignored", nlog, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R10 actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule